// File: doc/BRIEF.md
# Tagged Serial Shift-Out Transmitter

This block turns a parallel word into a serial stream and drives the receiver's bit clock itself. A one-cycle request loads the word into a holding register. The block then opens the frame with a tag pulse one data-clock period long, and during that period the outgoing clock stays low. After that, one bit is sent per data-clock period, most significant bit first. Each bit is placed on the line at a falling point of the outgoing clock, so it is settled for half a period before the rising edge that the receiver samples on.

Nothing is clocked by a divided clock. A phase counter running on the fast system clock produces a one-cycle rise strobe and a one-cycle fall strobe. The frame sequencer moves only on those strobes, so the outgoing clock, the tag and the data are all plain registers in one clock domain. The divide ratio `DIV` (fast cycles per outgoing clock period, even, at least 4) and the word width `WIDTH` (at least 2) are parameters.

Top module: `tag_shift_tx`

## Requirements
- R1: During reset, and at any time the block is idle, `dclk_o`, `sdata_o`, `tag_o` and `busy_o` are all low.
- R2: When `start_i` is high at a clock edge while `busy_o` is low, `busy_o` and `tag_o` are high from the next cycle. The value of `word_i` at that edge is the value that gets sent, and later changes of `word_i` have no effect on the frame.
- R3: `tag_o` is high for exactly `DIV` consecutive cycles per frame, `dclk_o` is low throughout that time, and the tag does not rise again before the frame ends.
- R4: After the tag there are exactly `WIDTH` bit periods of `DIV` cycles each. In every bit period `dclk_o` is low for the first `DIV/2` cycles and high for the last `DIV/2`, so a frame has exactly `WIDTH` rising edges, and none of them falls between the tag and the first bit.
- R5: Bit period k (k = 1..WIDTH) carries `word[WIDTH-k]`, so the MSB goes first. `sdata_o` changes only at the start of a bit period, and it is therefore stable for `DIV/2` cycles before each rising edge.
- R6: `busy_o` stays high for exactly `(WIDTH+1)*DIV` consecutive cycles per frame.
- R7: A `start_i` while `busy_o` is high is ignored. It causes no new tag and no change to the current frame.
- R8: After the last high phase, `dclk_o` and `sdata_o` drop low together with `busy_o`. If `start_i` is high in that first idle cycle, a new frame starts at once.
- R9: A synchronous reset asserted in the middle of a frame returns all outputs to idle on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send `word_i` |
| word_i | input | WIDTH | Parallel word to transmit |
| busy_o | output | 1 | A frame is in progress |
| dclk_o | output | 1 | Outgoing data clock |
| sdata_o | output | 1 | Serial data, MSB first |
| tag_o | output | 1 | Frame tag, one data-clock period long |

## Verification
Two things can fall in the same cycle: the fall strobe that ends the last bit period and returns the block to idle, and a waiting start request. The bench holds `start_i` high from mid-frame across the end of the frame. A correct block ignores the request while it is busy, shows exactly one idle cycle, and then opens a new tag. The cycle-level reference model predicts that single idle cycle and every output around it, and any merged or lost frame shows up as a mismatch there. Other starts land in the middle of a frame, and a reset lands in the middle of a bit period, to show that neither disturbs the stream.

// File: rtl/tst_pkg.sv
package tst_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_TAG   = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;
endpackage

// File: rtl/tst_divider.sv
// Phase counter on the fast clock; emits one-cycle strobes one cycle
// ahead of the outgoing clock's rise and fall points.
module tst_divider #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic rise_en,
    output logic fall_en
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] RISE_AT = CW'(DIV / 2 - 1);
    localparam logic [CW-1:0] WRAP_AT = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (!run) begin
            div_d.cnt = '0;
        end else if (div_q.cnt == WRAP_AT) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign rise_en = run && (div_q.cnt == RISE_AT);
    assign fall_en = run && (div_q.cnt == WRAP_AT);
endmodule

// File: rtl/tst_sequencer.sv
// Frame sequencer: tag period, then WIDTH bit periods, all stepped by strobes.
module tst_sequencer
    import tst_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             rise_en,
    input  logic             fall_en,
    output logic             busy_o,
    output logic             dclk_o,
    output logic             sdata_o,
    output logic             tag_o
);
    localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

    typedef struct packed {
        tx_state_e        state;
        logic [IW-1:0]    bidx;
        logic [WIDTH-1:0] word;
        logic             dclk;
        logic             sdata;
        logic             tag;
    } seq_t;

    localparam seq_t IDLE_S = '{state: TX_IDLE, bidx: '0, word: '0,
                                dclk: 1'b0, sdata: 1'b0, tag: 1'b0};

    seq_t seq_d, seq_q;
    logic [IW-1:0] bidx_inc;

    assign bidx_inc = seq_q.bidx + 1'b1;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            TX_IDLE: begin
                if (start_i) begin
                    seq_d.state = TX_TAG;
                    seq_d.bidx  = '0;
                    seq_d.word  = word_i;
                    seq_d.tag   = 1'b1;
                end
            end
            TX_TAG: begin
                // clock held low for the whole tag period
                if (fall_en) begin
                    seq_d.state = TX_SHIFT;
                    seq_d.tag   = 1'b0;
                    seq_d.bidx  = '0;
                    seq_d.sdata = seq_q.word[LAST];
                end
            end
            TX_SHIFT: begin
                if (rise_en) begin
                    seq_d.dclk = 1'b1;
                end
                if (fall_en) begin
                    seq_d.dclk = 1'b0;
                    if (seq_q.bidx == LAST) begin
                        seq_d = IDLE_S;
                    end else begin
                        seq_d.bidx  = bidx_inc;
                        seq_d.sdata = seq_q.word[LAST - bidx_inc];
                    end
                end
            end
            default: seq_d = IDLE_S;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= IDLE_S;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o  = (seq_q.state != TX_IDLE);
    assign dclk_o  = seq_q.dclk;
    assign sdata_o = seq_q.sdata;
    assign tag_o   = seq_q.tag;
endmodule

// File: rtl/tag_shift_tx.sv
module tag_shift_tx #(
    parameter int DIV   = 50,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] word_i,
    output logic             busy_o,
    output logic             dclk_o,
    output logic             sdata_o,
    output logic             tag_o
);
    logic rise_en;
    logic fall_en;
    logic busy;

    tst_divider #(.DIV(DIV)) u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .rise_en (rise_en),
        .fall_en (fall_en)
    );

    tst_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .word_i  (word_i),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .busy_o  (busy),
        .dclk_o  (dclk_o),
        .sdata_o (sdata_o),
        .tag_o   (tag_o)
    );

    assign busy_o = busy;
endmodule

// File: rtl/tag_shift_tx_chk.sv
module tag_shift_tx_chk #(
    parameter int DIV   = 50,
    parameter int WIDTH = 16
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic dclk_o,
    input logic sdata_o,
    input logic tag_o
);
    localparam int FRAME = (WIDTH + 1) * DIV;

    int run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= 0;
        end else if (busy_o) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!dclk_o && !tag_o && !sdata_o));

    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && tag_o));

    p_tag_clock_low_r3: assert property (@(posedge clk) disable iff (rst)
        tag_o |-> !dclk_o);

    p_tag_opens_frame_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tag_o) |-> $rose(busy_o));

    p_clock_in_bits_r4: assert property (@(posedge clk) disable iff (rst)
        dclk_o |-> (busy_o && !tag_o));

    p_data_settled_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk_o) |-> $stable(sdata_o));

    p_busy_bound_r6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run_cnt < FRAME));

    p_busy_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && run_cnt == FRAME - 1) |=> !busy_o);
endmodule

bind tag_shift_tx tag_shift_tx_chk #(.DIV(DIV), .WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .dclk_o  (dclk_o),
    .sdata_o (sdata_o),
    .tag_o   (tag_o)
);

// File: tb/tag_shift_tx_bench.sv
module tag_shift_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;
    localparam int WIDTH      = 6;
    localparam int FRAME      = (WIDTH + 1) * DIV;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [WIDTH-1:0] word_i = '0;
    logic             busy_o, dclk_o, sdata_o, tag_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    bit checking = 0;

    // behavioural reference
    bit               m_act = 0;
    int               m_t = 0;
    logic [WIDTH-1:0] m_word = '0;
    bit               aborted = 0;

    // frame monitors
    bit prev_busy = 0;
    bit prev_dclk = 0;
    int rises = 0;
    int tags  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tag_shift_tx #(.DIV(DIV), .WIDTH(WIDTH)) u_tag_shift_tx (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .word_i  (word_i),
        .busy_o  (busy_o),
        .dclk_o  (dclk_o),
        .sdata_o (sdata_o),
        .tag_o   (tag_o)
    );

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s at %0t: got=%b exp=%b", req, what, $time, got, exp);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string req, input string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s at %0t: got=%0d exp=%0d", req, what, $time, got, exp);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            if (m_act) aborted = 1;
            m_act = 0;
            m_t   = 0;
        end else if (m_act) begin
            m_t++;
            if (m_t == FRAME) m_act = 0;
        end else if (start_i) begin
            m_act  = 1;
            m_t    = 0;
            m_word = word_i;
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            logic e_busy, e_dclk, e_sdata, e_tag;
            int p, q;
            p = m_t / DIV;
            q = m_t % DIV;
            e_busy  = m_act;
            e_tag   = m_act && (p == 0);
            e_dclk  = m_act && (p >= 1) && (q >= DIV / 2);
            e_sdata = (m_act && p >= 1) ? m_word[WIDTH - p] : 1'b0;
            chk(busy_o,  e_busy,  "R6", "busy");
            chk(tag_o,   e_tag,   "R3", "tag");
            chk(dclk_o,  e_dclk,  "R4", "dclk");
            chk(sdata_o, e_sdata, "R5", "sdata");
            if (!busy_o) chk(dclk_o | sdata_o | tag_o, 1'b0, "R1", "idle outputs");

            if (!prev_busy && busy_o) begin
                rises = 0;
                tags  = 0;
                aborted = 0;
            end
            if (busy_o && tag_o) tags++;
            if (dclk_o && !prev_dclk) rises++;
            if (prev_busy && !busy_o && !aborted) begin
                chk_int(rises, WIDTH, "R4", "rising edges per frame");
                chk_int(tags,  DIV,   "R3", "tag cycles per frame");
            end
            prev_busy = busy_o;
            prev_dclk = dclk_o;
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic send(input logic [WIDTH-1:0] w);
        @(negedge clk);
        start_i = 1'b1;
        word_i  = w;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(busy_o, 1'b0, "R1", "busy in reset");
        chk(dclk_o, 1'b0, "R1", "dclk in reset");
        chk(sdata_o, 1'b0, "R1", "sdata in reset");
        chk(tag_o, 1'b0, "R1", "tag in reset");
        rst = 1'b0;
        checking = 1;
        repeat (4) @(negedge clk);

        // R2/R5: plain frame, word_i changed mid-frame must not matter
        send(6'b101101);
        chk(tag_o, 1'b1, "R2", "tag after start");
        word_i = 6'b010010;
        repeat (20) @(negedge clk);
        // R7: start while busy is ignored
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_idle();
        repeat (3) @(negedge clk);

        // R8: start held across the frame end; new frame right after idle cycle
        send(6'b111111);
        repeat (30) @(negedge clk);
        start_i = 1'b1;
        word_i  = 6'b100001;
        while (busy_o) @(negedge clk);
        chk(dclk_o | sdata_o, 1'b0, "R8", "lines low at frame end");
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o & tag_o, 1'b1, "R8", "back-to-back frame opens");
        wait_idle();

        // all-zero word
        send(6'b000000);
        wait_idle();

        // R9: reset in the middle of a bit period
        send(6'b110011);
        repeat (DIV * 3 + DIV / 2 + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy_o | dclk_o | sdata_o | tag_o, 1'b0, "R9", "idle after mid-frame reset");
        repeat (4) @(negedge clk);

        send(6'b011010);
        wait_idle();
        repeat (4) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule